// File: doc/BRIEF.md
# Key-Guarded Peripheral Reset Register Block

This block holds a small set of system control registers behind a software lock. A register bus with one access per cycle reaches three locations: a lock entry, an unlock entry and a reset-control register. A fourth, read-only location reports whether the block is open. The reset-control register accepts writes only while the block is open. Its low four bits drive four reset lines into a serial peripheral.

Software opens the block by writing one 16-bit key to the unlock entry. It changes the reset bits, then closes the block again by writing a different key to the lock entry. Any other value written to either entry is discarded. So is any reset-register write made while the block is closed. The block does not time how long a reset is held. Software must wait long enough between asserting a reset and releasing it.

Top module: `keyguard_rst`

## Requirements
- R1: After system reset the block is locked and all four lines of `periph_rst` are 0.
- R2: A bus write of exactly 0x0000DF0D to the unlock entry (byte offset 0x004) makes the block unlocked from the next clock edge.
- R3: A bus write of exactly 0x0000767B to the lock entry (byte offset 0x000) makes the block locked from the next clock edge.
- R4: A write of any other value to the lock or unlock entry leaves the lock state unchanged. This includes each key written to the other entry.
- R5: While unlocked, a write to the reset register (offset 0x010) loads `wdata[3:0]` into `periph_rst` at that edge. A 1 asserts a line and a 0 releases it.
- R6: While locked, a write to the reset register is ignored and `periph_rst` keeps its value.
- R7: A read of the status location (offset 0x008) returns bit 0 = 1 when unlocked and 0 when locked, with all other bits 0.
- R8: A read of the reset register returns the current four reset bits in [3:0] and zeros above, in either lock state.
- R9: Writes to unmapped offsets change neither the lock state nor `periph_rst`. Reads of unmapped offsets, of the two key entries, or with `bus_sel` low return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| periph_rst | output | 4 | Reset lines to the peripheral, 1 = held in reset |

## Verification
The properties assume that each bus access lasts one cycle. They also assume that `bus_addr` and `bus_wdata` are stable across the clock edge where a write is taken, and that reads are judged combinationally in the cycle they are issued. The bench changes inputs only on the falling edge and holds every access for exactly one cycle. Its random writes mix exact keys, keys aimed at the wrong entry and arbitrary words. Addresses are drawn from the mapped offsets plus one unmapped offset, so every lock transition and every ignore path is reached.

// File: rtl/kg_pkg.sv
package kg_pkg;
    localparam int unsigned KEY_W = 16;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_st_e;

    typedef struct packed {
        logic wr_lock;
        logic wr_unlock;
        logic wr_prst;
        logic rd_status;
        logic rd_prst;
    } kg_dec_t;
endpackage

// File: rtl/kg_lock_ctrl.sv
module kg_lock_ctrl #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] OPEN_WORD  = 32'h0000_DF0D,
    parameter logic [DATA_W-1:0] CLOSE_WORD = 32'h0000_767B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lock,
    input  logic              wr_unlock,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    import kg_pkg::*;

    typedef struct packed {
        lock_st_e st;
    } lock_s_t;

    lock_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_unlock && (wdata == OPEN_WORD)) begin
            s_d.st = ST_OPEN;
        end else if (wr_lock && (wdata == CLOSE_WORD)) begin
            s_d.st = ST_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= ST_LOCKED;
        end else begin
            s_q <= s_d;
        end
    end

    assign unlocked = (s_q.st == ST_OPEN);
endmodule

// File: rtl/kg_rst_bank.sv
module kg_rst_bank #(
    parameter int unsigned N_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             unlocked,
    input  logic [N_RST-1:0] wbits,
    output logic [N_RST-1:0] rst_bits
);
    typedef struct packed {
        logic [N_RST-1:0] bits;
    } bank_s_t;

    bank_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && unlocked) begin
            s_d.bits = wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.bits <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_bits = s_q.bits;
endmodule

// File: rtl/kg_rdmux.sv
module kg_rdmux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_RST  = 4
) (
    input  logic             rd_status,
    input  logic             rd_prst,
    input  logic             unlocked,
    input  logic [N_RST-1:0] rst_bits,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_status) begin
            rdata[0] = unlocked;
        end else if (rd_prst) begin
            rdata[N_RST-1:0] = rst_bits;
        end
    end
endmodule

// File: rtl/keyguard_rst.sv
module keyguard_rst #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_RST  = 4,
    parameter logic [ADDR_W-1:0] OFF_LOCK   = 12'h000,
    parameter logic [ADDR_W-1:0] OFF_UNLOCK = 12'h004,
    parameter logic [ADDR_W-1:0] OFF_STAT   = 12'h008,
    parameter logic [ADDR_W-1:0] OFF_PRST   = 12'h010,
    parameter logic [15:0] OPEN_KEY  = 16'hDF0D,
    parameter logic [15:0] CLOSE_KEY = 16'h767B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_RST-1:0]  periph_rst
);
    import kg_pkg::*;

    localparam int unsigned PAD_W = DATA_W - KEY_W;
    localparam logic [DATA_W-1:0] OPEN_WORD  = {{PAD_W{1'b0}}, OPEN_KEY};
    localparam logic [DATA_W-1:0] CLOSE_WORD = {{PAD_W{1'b0}}, CLOSE_KEY};

    kg_dec_t dec;
    logic    unlocked;

    always_comb begin
        dec           = '0;
        dec.wr_lock   = bus_sel &&  bus_wr && (bus_addr == OFF_LOCK);
        dec.wr_unlock = bus_sel &&  bus_wr && (bus_addr == OFF_UNLOCK);
        dec.wr_prst   = bus_sel &&  bus_wr && (bus_addr == OFF_PRST);
        dec.rd_status = bus_sel && !bus_wr && (bus_addr == OFF_STAT);
        dec.rd_prst   = bus_sel && !bus_wr && (bus_addr == OFF_PRST);
    end

    kg_lock_ctrl #(
        .DATA_W    (DATA_W),
        .OPEN_WORD (OPEN_WORD),
        .CLOSE_WORD(CLOSE_WORD)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lock  (dec.wr_lock),
        .wr_unlock(dec.wr_unlock),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    kg_rst_bank #(
        .N_RST(N_RST)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dec.wr_prst),
        .unlocked(unlocked),
        .wbits   (bus_wdata[N_RST-1:0]),
        .rst_bits(periph_rst)
    );

    kg_rdmux #(
        .DATA_W(DATA_W),
        .N_RST (N_RST)
    ) u_rd (
        .rd_status(dec.rd_status),
        .rd_prst  (dec.rd_prst),
        .unlocked (unlocked),
        .rst_bits (periph_rst),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/kg_chk.sv
module kg_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_RST  = 4,
    parameter logic [ADDR_W-1:0] OFF_LOCK   = 12'h000,
    parameter logic [ADDR_W-1:0] OFF_UNLOCK = 12'h004,
    parameter logic [ADDR_W-1:0] OFF_STAT   = 12'h008,
    parameter logic [ADDR_W-1:0] OFF_PRST   = 12'h010,
    parameter logic [15:0] OPEN_KEY  = 16'hDF0D,
    parameter logic [15:0] CLOSE_KEY = 16'h767B
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_RST-1:0]  periph_rst,
    input logic              unlocked
);
    logic wr_any, open_hit, close_hit, prst_wr;
    assign wr_any    = bus_sel && bus_wr;
    assign open_hit  = wr_any && (bus_addr == OFF_UNLOCK) && (bus_wdata == DATA_W'(OPEN_KEY));
    assign close_hit = wr_any && (bus_addr == OFF_LOCK) && (bus_wdata == DATA_W'(CLOSE_KEY));
    assign prst_wr   = wr_any && (bus_addr == OFF_PRST);

    // R2
    unlock_key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_hit |=> unlocked);
    // R3
    lock_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_hit |=> !unlocked);
    // R4
    lock_state_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_hit && !close_hit) |=> $stable(unlocked));
    // R5
    open_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_wr && unlocked) |=> (periph_rst == $past(bus_wdata[N_RST-1:0])));
    // R6
    locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prst_wr && unlocked) |=> $stable(periph_rst));
    // R7
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFF_STAT) |-> (bus_rdata == DATA_W'(unlocked)));
    // R8
    prst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFF_PRST) |-> (bus_rdata == DATA_W'(periph_rst)));
endmodule

bind keyguard_rst kg_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .N_RST     (N_RST),
    .OFF_LOCK  (OFF_LOCK),
    .OFF_UNLOCK(OFF_UNLOCK),
    .OFF_STAT  (OFF_STAT),
    .OFF_PRST  (OFF_PRST),
    .OPEN_KEY  (OPEN_KEY),
    .CLOSE_KEY (CLOSE_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .periph_rst(periph_rst),
    .unlocked  (unlocked)
);

// File: tb/keyguard_rst_bench.sv
`timescale 1ns/1ps
module keyguard_rst_bench;
    localparam logic [11:0] A_LOCK = 12'h000, A_UNLK = 12'h004,
                            A_STAT = 12'h008, A_PRST = 12'h010, A_NONE = 12'h100;
    localparam logic [31:0] K_OPEN = 32'h0000_DF0D, K_CLOSE = 32'h0000_767B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  periph_rst;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit m_open = 1'b0;
    logic [3:0] m_rst = '0;

    always #4 clk = ~clk;

    keyguard_rst u_keyguard_rst (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_rst(periph_rst)
    );

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == A_STAT) return {31'b0, m_open};
        if (a == A_PRST) return {28'b0, m_rst};
        return 32'b0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        if (a == A_UNLK && d == K_OPEN) m_open = 1'b1;
        else if (a == A_LOCK && d == K_CLOSE) m_open = 1'b0;
        else if (a == A_PRST && m_open) m_rst = d[3:0];
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check({tag, " periph_rst"}, {28'b0, periph_rst}, {28'b0, m_rst});
    endtask

    task automatic rd(logic [11:0] a, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd20231));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 periph_rst", {28'b0, periph_rst}, 32'h0);
        rd(A_STAT, "R1 status locked");
        // R6 locked write ignored
        wr(A_PRST, 32'hF, "R6");
        rd(A_PRST, "R6 R8 readback locked");
        // R4 wrong keys / swapped entries
        wr(A_UNLK, K_CLOSE, "R4 swap");
        wr(A_LOCK, K_OPEN, "R4 swap2");
        wr(A_UNLK, 32'h0001_DF0D, "R4 upper");
        rd(A_STAT, "R4 still locked");
        // R2 unlock
        wr(A_UNLK, K_OPEN, "R2");
        rd(A_STAT, "R2 status open");
        // R5 assert/release
        wr(A_PRST, 32'hFFFF_FFFA, "R5 load");
        rd(A_PRST, "R5 R8 readback");
        wr(A_PRST, 32'h0000_0005, "R5 flip");
        // R9 unmapped write, reads of key entries
        wr(A_NONE, K_CLOSE, "R9 unmapped");
        rd(A_STAT, "R9 still open");
        rd(A_LOCK, "R9 key entry reads zero");
        rd(A_NONE, "R9 unmapped reads zero");
        // R3 lock
        wr(A_LOCK, K_CLOSE, "R3");
        rd(A_STAT, "R3 status locked");
        wr(A_PRST, 32'h0, "R6 after relock");
        rd(A_PRST, "R8 readback while locked");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            int unsigned pick;
            pick = $urandom % 5;
            case (pick)
                0: a = A_LOCK; 1: a = A_UNLK; 2: a = A_STAT;
                3: a = A_PRST; default: a = A_NONE;
            endcase
            case ($urandom % 4)
                0: d = K_OPEN; 1: d = K_CLOSE; default: d = $urandom;
            endcase
            if ($urandom % 3 == 0) rd(a, "R7 R8 R9 random read");
            else wr(a, d, "R2 R3 R4 R5 R6 random write");
        end
        @(negedge clk);
        bus_sel = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule